// File: doc/BRIEF.md
# Interleaved Storage Element Scheduler

This block sits between a requester and a main storage built from several independent elements that each need a long storage cycle. Each doubleword request is routed to one element by the low-order bits of its doubleword address. The remaining upper bits give the row inside that element. Each element stays occupied for a full storage cycle after an access starts. Requests that land on idle elements can still start one per processor cycle. A request aimed at an occupied element is held off with a busy indication until that element frees up.

The request side is valid/ready. The requester raises `req_valid` with the address, the write flag and the write data. It keeps all of them stable until it sees `req_ready` high at a rising edge, and only that edge accepts the request. `req_ready` is the busy indication: it is low exactly when the addressed element is occupied, and it does not depend on `req_valid`. One cycle after acceptance the block emits a one-cycle start pulse with the element number, the row, the write flag and the write data. The storage array must present read data for that element and row on `mem_rdata` during the start cycle.

Read data comes back on the response port a fixed number of cycles after the start pulse. Since at most one access starts per cycle and the latency is fixed, responses come back in request order. The response port has no ready: the requester must always take a response in the cycle it is valid. Writes produce no response.

Top module: `ilv_bank_sched`

## Requirements
- R1: An accepted request produces, in the next cycle, a one-cycle `mem_start` pulse. The pulse carries `mem_bank` equal to the low log2(NUM_BANKS) bits of the request address (3 bits at the default of 8 elements, 4 bits when NUM_BANKS is 16), `mem_row` equal to the remaining upper address bits, and the request's write flag and write data.
- R2: `req_ready` is high exactly when the element selected by the current `req_addr` is idle.
- R3: After an access starts on an element, that element stays busy for BUSY_CYC (default 14) cycles. A request held against it is accepted exactly BUSY_CYC cycles after the previous acceptance, and no earlier.
- R4: Requests to different idle elements are accepted in consecutive cycles. The eight consecutive doubleword addresses of a 64-byte block are accepted with no busy cycle.
- R5: A request that is not accepted starts nothing. Each accepted request produces exactly one start pulse.
- R6: A read returns `rsp_valid` with the data stored at its address exactly RD_LAT (default 4) cycles after its start pulse, in request order.
- R7: A write (`req_we` = 1) updates the storage at its address and produces no response.
- R8: Reset clears every element's busy state and drops any read data still in flight. After reset every element is ready and no response appears for accesses started before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed element idle; low means busy |
| req_addr | input | ADDR_W | Doubleword address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| mem_start | output | 1 | One-cycle access start toward storage |
| mem_bank | output | log2(NUM_BANKS) | Element being started |
| mem_row | output | ADDR_W-log2(NUM_BANKS) | Row inside the element |
| mem_we | output | 1 | Started access is a write |
| mem_wdata | output | DATA_W | Data to write |
| mem_rdata | input | DATA_W | Storage read data during the start cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |

## Verification
Some properties are checked on every cycle. Each acceptance is followed by a start pulse carrying the right element and row, and a stalled request never starts. No element is accepted twice within its storage cycle. `rsp_valid` tracks read starts delayed by the fixed latency. Other behaviour only the bench scenarios can show. These are the correct data coming back in order, the exact stall count of a held request, gap-free streaming through a 64-byte block, strided patterns that collide part-way, and dropping of in-flight reads across a mid-run reset.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Storage cycle of one element, counted in processor cycles
  parameter int unsigned STORAGE_CYCLES = 14;
  // Fixed read return latency after the start pulse
  parameter int unsigned RETURN_LATENCY = 4;

  function automatic bit bank_count_ok(int unsigned n);
    return (n == 8) || (n == 16);
  endfunction
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BANK_W = 3
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic [BANK_W-1:0]        bank,
  output logic [ADDR_W-BANK_W-1:0] row
);
  // Low doubleword bits pick the element so neighbours interleave
  assign bank = addr[BANK_W-1:0];
  assign row  = addr[ADDR_W-1:BANK_W];
endmodule

// File: rtl/ilv_bank_timers.sv
module ilv_bank_timers #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BUSY_CYC  = 14,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned CW       = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BANK_W-1:0]    start_bank,
  output logic [NUM_BANKS-1:0] idle
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (start && (start_bank == BANK_W'(b))) begin
        cnt <= CW'(BUSY_CYC - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
    assign idle[b] = (cnt == '0);
  end
endmodule

// File: rtl/ilv_return_pipe.sv
module ilv_return_pipe #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned RD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [RD_LAT-1:0] vld;
  logic [DATA_W-1:0] dat [RD_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      vld[0] <= in_valid;
      for (int k = 1; k < RD_LAT; k++) vld[k] <= vld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) dat[0] <= in_data;
    for (int k = 1; k < RD_LAT; k++) begin
      if (vld[k-1]) dat[k] <= dat[k-1];
    end
  end

  assign out_valid = vld[RD_LAT-1];
  assign out_data  = dat[RD_LAT-1];
endmodule

// File: rtl/ilv_bank_sched.sv
module ilv_bank_sched #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned BUSY_CYC  = ilv_pkg::STORAGE_CYCLES,
  parameter int unsigned RD_LAT    = ilv_pkg::RETURN_LATENCY,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W    = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_start,
  output logic [BANK_W-1:0] mem_bank,
  output logic [ROW_W-1:0]  mem_row,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  if (!ilv_pkg::bank_count_ok(NUM_BANKS)) begin : g_bad_count
    $error("NUM_BANKS must be 8 or 16");
  end

  logic [BANK_W-1:0]    req_bank;
  logic [ROW_W-1:0]     req_row;
  logic [NUM_BANKS-1:0] bank_idle;
  logic                 accept;

  ilv_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_split (
    .addr (req_addr),
    .bank (req_bank),
    .row  (req_row)
  );

  ilv_bank_timers #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) u_timers (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_bank (req_bank),
    .idle       (bank_idle)
  );

  assign req_ready = bank_idle[req_bank];
  assign accept    = req_valid && req_ready;

  // Registered start toward the storage elements
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_start <= 1'b0;
      mem_bank  <= '0;
      mem_row   <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_start <= accept;
      if (accept) begin
        mem_bank  <= req_bank;
        mem_row   <= req_row;
        mem_we    <= req_we;
        mem_wdata <= req_wdata;
      end
    end
  end

  ilv_return_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mem_start && !mem_we),
    .in_data   (mem_rdata),
    .out_valid (rsp_valid),
    .out_data  (rsp_data)
  );
endmodule

// File: rtl/ilv_bank_sched_chk.sv
module ilv_bank_sched_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BUSY_CYC  = 14,
  parameter int unsigned RD_LAT    = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned AGE_W    = $clog2(BUSY_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_start,
  input logic [BANK_W-1:0] mem_bank,
  input logic [ADDR_W-BANK_W-1:0] mem_row,
  input logic              mem_we,
  input logic              rsp_valid
);
  logic [AGE_W-1:0] age [NUM_BANKS];
  logic [RD_LAT-1:0] rd_sh;
  logic              acc;
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) age[b] <= AGE_W'(BUSY_CYC);
      rd_sh <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (acc && (req_addr[BANK_W-1:0] == BANK_W'(b))) age[b] <= AGE_W'(1);
        else if (age[b] < AGE_W'(BUSY_CYC)) age[b] <= age[b] + AGE_W'(1);
      end
      rd_sh[0] <= mem_start && !mem_we;
      for (int k = 1; k < RD_LAT; k++) rd_sh[k] <= rd_sh[k-1];
    end
  end

  assert_start_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_start && mem_bank == $past(req_addr[BANK_W-1:0])
                                  && mem_row == $past(req_addr[ADDR_W-1:BANK_W])));

  assert_bank_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (age[req_addr[BANK_W-1:0]] >= AGE_W'(BUSY_CYC)));

  assert_stall_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !mem_start);

  assert_return_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == rd_sh[RD_LAT-1]);
endmodule

bind ilv_bank_sched ilv_bank_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .mem_start(mem_start), .mem_bank(mem_bank),
  .mem_row(mem_row), .mem_we(mem_we), .rsp_valid(rsp_valid)
);

// File: tb/sim_ilv_bank_sched.sv
module sim_ilv_bank_sched;
  localparam int NB = 8;
  localparam int BW = 3;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam int LAT = 4;
  localparam int BUSY = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_we = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic mem_start;
  logic [BW-1:0] mem_bank;
  logic [AW-BW-1:0] mem_row;
  logic mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  ilv_bank_sched u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .mem_start(mem_start), .mem_bank(mem_bank), .mem_row(mem_row),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // Behavioral storage array, indexed by full doubleword address
  logic [DW-1:0] store [1 << AW];
  logic [DW-1:0] shadow [1 << AW];
  assign mem_rdata = store[{mem_row, mem_bank}];
  always @(posedge clk) if (mem_start && mem_we) store[{mem_row, mem_bank}] <= mem_wdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;
  int rsp_seen = 0;

  typedef struct { logic [DW-1:0] d; int c; } rexp_t;
  typedef struct { logic [BW-1:0] b; logic [AW-BW-1:0] r; logic w; int c; } sexp_t;
  rexp_t rq[$];
  sexp_t sq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares starts and responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_start) begin
        if (sq.size() == 0) chk(0, "R5 start without request", 1, 0);
        else begin
          sexp_t s;
          s = sq.pop_front();
          chk(mem_bank == s.b, "R1 bank", mem_bank, s.b);
          chk(mem_row == s.r, "R1 row", mem_row, s.r);
          chk(mem_we == s.w, "R1 write flag", mem_we, s.w);
          chk(cyc == s.c, "R1 start cycle", cyc, s.c);
        end
      end
      if (rsp_valid) begin
        rsp_seen++;
        if (rq.size() == 0) chk(0, "R7/R8 unexpected response", 1, 0);
        else begin
          rexp_t e;
          e = rq.pop_front();
          chk(rsp_data == e.d, "R6 read data", rsp_data, e.d);
          chk(cyc == e.c, "R6 return cycle", cyc, e.c);
        end
      end
    end
  end

  // Driver: holds the request stable until accepted
  task automatic send(input int a, input bit w, input logic [DW-1:0] wd,
                      output int acc, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_we = w; req_wdata = wd;
    stalls = 0;
    forever begin
      #1;
      if (req_ready) begin acc = cyc; break; end
      stalls++;
      @(negedge clk);
    end
    sq.push_back('{b: BW'(a), r: (AW-BW)'(a >> BW), w: w, c: acc + 1});
    if (!w) rq.push_back('{d: shadow[a], c: acc + 1 + LAT});
    else shadow[a] = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int acc, st, prev, a0;
    for (int i = 0; i < (1 << AW); i++) begin
      store[i]  = {32'hC0DE_0000 | 32'(i), 32'(i * 7 + 3)};
      shadow[i] = store[i];
    end
    repeat (5) @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 reset rsp_valid", rsp_valid, 0);
    chk(mem_start == 1'b0, "R8 reset mem_start", mem_start, 0);
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) begin
      @(negedge clk); req_addr = AW'(b); #1;
      chk(req_ready == 1'b1, "R2 idle after reset", req_ready, 1);
    end

    // R4: a 64-byte block streams with no busy cycle
    for (int i = 0; i < 8; i++) begin
      send(16 + i, 1'b0, '0, acc, st);
      chk(st == 0, "R4 block stalls", st, 0);
      if (i > 0) chk(acc == prev + 1, "R4 consecutive accept", acc - prev, 1);
      prev = acc;
    end
    repeat (20) @(negedge clk);

    // R3 / R2: back-to-back on one element
    send(40, 1'b0, '0, a0, st);
    send(48, 1'b0, '0, acc, st);
    chk(st == BUSY - 1, "R2/R3 same-element stalls", st, BUSY - 1);
    chk(acc - a0 == BUSY, "R3 same-element spacing", acc - a0, BUSY);
    repeat (20) @(negedge clk);

    // R7: writes, then read-back
    for (int i = 0; i < 8; i++) send(100 + i, 1'b1, 64'h5A00_0000_0000_0000 | 64'(i * 17), acc, st);
    repeat (BUSY + 2) @(negedge clk);
    chk(rq.size() == 0, "R7 no response for writes", rq.size(), 0);
    for (int i = 0; i < 8; i++) send(100 + i, 1'b0, '0, acc, st);
    repeat (20) @(negedge clk);

    // Collision after one other element
    send(200, 1'b0, '0, a0, st);
    send(201, 1'b0, '0, acc, st);
    send(208, 1'b0, '0, acc, st);
    chk(st == BUSY - 2, "R3 collision after one", st, BUSY - 2);
    repeat (20) @(negedge clk);

    // Stride-2 pattern: fifth request revisits the first element
    for (int i = 0; i < 5; i++) begin
      send(300 + 2 * i, 1'b0, '0, acc, st);
      if (i < 4) chk(st == 0, "R4 stride-2 no stall", st, 0);
      else chk(st == BUSY - 4, "R3 stride-2 revisit stalls", st, BUSY - 4);
    end
    repeat (20) @(negedge clk);
    chk(rq.size() == 0, "R6 all reads returned", rq.size(), 0);

    // R8: reset with reads in flight
    send(400, 1'b0, '0, acc, st);
    send(401, 1'b0, '0, acc, st);
    send(402, 1'b0, '0, acc, st);
    @(negedge clk); #1;
    rst_n = 1'b0;
    rq.delete(); sq.delete();
    rsp_seen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    req_addr = AW'(400); #1;
    chk(req_ready == 1'b1, "R8 element idle after reset", req_ready, 1);
    repeat (12) @(negedge clk);
    chk(rsp_seen == 0, "R8 in-flight reads dropped", rsp_seen, 0);
    send(400, 1'b0, '0, acc, st);
    chk(st == 0, "R8 immediate accept after reset", st, 0);
    repeat (10) @(negedge clk);
    chk(rq.size() == 0, "R6 post-reset read returned", rq.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule